// File: doc/BRIEF.md
# Single-Bit Level Synchronizer with Source-Side Hazard Filter

This block moves one slowly changing control level from a source clock domain into an unrelated destination clock domain. The raw level may come straight from combinational logic, so it can show short static or dynamic hazards. A register clocked by the source clock captures the raw level first. Only that registered copy reaches the crossing, which therefore makes one clean transition per change. A chain of destination flops then carries the value across. The first flop of the chain may go metastable, and the flops after it keep that state away from downstream logic.

The number of destination stages is a parameter, with a minimum of two. A second parameter selects which edge of the destination clock the first stage uses. With the falling edge, the first stage captures half a cycle earlier, and the latency window moves down by half a destination period. Each domain has its own active-low asynchronous reset, and every flop resets to 0. The block has no data stream, so there is no valid/ready handshake. All pins are plain levels.

Top module: `cdc_level_sync`

## Requirements
- R1: While `dst_rst_n` is low, `dst_level` is 0, and it is still 0 after the first destination edge that follows the release.
- R2: While `src_rst_n` is low, the source register holds 0 whatever the raw input does. With the destination clock running, `dst_level` reaches 0 within STAGES destination periods.
- R3: The raw input is sampled only on rising edges of `src_clk`. A hazard or pulse that starts and ends between two such edges never appears on `dst_level`.
- R4: With `FIRST_EDGE = CAPTURE_RISE`, every stage uses the rising edge of `dst_clk`. The output changes more than STAGES-1 and at most STAGES destination periods after the source register changes.
- R5: With `FIRST_EDGE = CAPTURE_FALL`, the first stage uses the falling edge of `dst_clk` and the rest use the rising edge. The latency window becomes more than STAGES-1.5 and at most STAGES-0.5 periods, for example 0.5 to 1.5 periods for two stages.
- R6: Every rise or fall of `dst_level` is preceded by the first destination stage holding the new value. The number of output transitions equals the number of source-register transitions that a destination capture edge observed.
- R7: Once the source register stays stable, `dst_level` equals it within STAGES destination periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| src_level_raw | input | 1 | Raw control level, possibly glitchy, from source-domain logic |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| dst_level | output | 1 | Synchronized control level in the destination domain |

## Verification
Suppose the source register were bypassed or clocked wrongly. A raw hazard placed between source edges would then show up as a short spurious pulse on `dst_level`, two or three destination cycles later. A chain that is too short or too long shows as a latency outside the R4 or R5 window, and a latency sweep across all source-to-destination phase offsets catches it within one transition. A wrong first-stage edge moves every transition by half a period, and the bench compares against a per-edge model every cycle, so the mismatch is reported on the very next sample.

// File: rtl/cdc_level_pkg.sv
package cdc_level_pkg;
  timeunit 1ns;
  timeprecision 10ps;

  // Edge used by the first destination capture flop.
  typedef enum logic {
    CAPTURE_RISE = 1'b0,
    CAPTURE_FALL = 1'b1
  } capture_edge_e;

  // Fewest destination stages that still give one settling cycle.
  localparam int MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/cdc_src_flop.sv
// Source-domain capture register: filters combinational hazards so the
// crossing net only ever changes once per source edge.
module cdc_src_flop (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  timeunit 1ns;
  timeprecision 10ps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end
endmodule

// File: rtl/cdc_dst_chain.sv
// Destination-side synchronizer chain. First stage edge is selectable.
module cdc_dst_chain
  import cdc_level_pkg::*;
#(
  parameter int            STAGES     = 2,
  parameter capture_edge_e FIRST_EDGE = CAPTURE_RISE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic first_q,
  output logic q
);
  timeunit 1ns;
  timeprecision 10ps;

  localparam int TAIL = STAGES - 1;

  generate
    if (STAGES < MIN_SYNC_STAGES) begin : g_bad_depth
      $error("cdc_dst_chain: STAGES must be at least %0d", MIN_SYNC_STAGES);
    end
  endgenerate

  // First capture stage: may go metastable, never feeds logic directly.
  generate
    if (FIRST_EDGE == CAPTURE_FALL) begin : g_first_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) first_q <= 1'b0;
        else        first_q <= d;
      end
    end else begin : g_first_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) first_q <= 1'b0;
        else        first_q <= d;
      end
    end
  endgenerate

  // Settling stages, all on the rising edge.
  logic [TAIL-1:0] tail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail <= '0;
    end else begin
      tail[0] <= first_q;
      for (int i = 1; i < TAIL; i++) begin
        tail[i] <= tail[i-1];
      end
    end
  end

  assign q = tail[TAIL-1];
endmodule

// File: rtl/cdc_level_sync.sv
module cdc_level_sync
  import cdc_level_pkg::*;
#(
  parameter int            STAGES     = 2,
  parameter capture_edge_e FIRST_EDGE = CAPTURE_RISE
) (
  input  logic src_clk,
  input  logic src_rst_n,
  input  logic src_level_raw,
  input  logic dst_clk,
  input  logic dst_rst_n,
  output logic dst_level
);
  timeunit 1ns;
  timeprecision 10ps;

  logic src_hold;    // registered source level, the only net that crosses
  logic sync_first;  // first destination stage

  cdc_src_flop u_src (
    .clk   (src_clk),
    .rst_n (src_rst_n),
    .d     (src_level_raw),
    .q     (src_hold)
  );

  cdc_dst_chain #(
    .STAGES     (STAGES),
    .FIRST_EDGE (FIRST_EDGE)
  ) u_dst (
    .clk     (dst_clk),
    .rst_n   (dst_rst_n),
    .d       (src_hold),
    .first_q (sync_first),
    .q       (dst_level)
  );
endmodule

// File: rtl/cdc_level_sync_chk.sv
module cdc_level_sync_chk #(
  parameter int STAGES = 2
) (
  input logic src_clk,
  input logic src_rst_n,
  input logic dst_clk,
  input logic dst_rst_n,
  input logic src_hold,
  input logic sync_first,
  input logic dst_level
);
  timeunit 1ns;
  timeprecision 10ps;

  localparam int CW = $clog2(STAGES + 2) + 1;
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [CW-1:0] LIMIT = CW'(STAGES);

  // Counts destination edges since the source register last changed while
  // the output still disagrees with it.
  logic [CW-1:0] lag_cnt;
  logic          prev_src;
  logic          seen_hi, seen_lo;

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      lag_cnt  <= '0;
      prev_src <= 1'b0;
    end else begin
      prev_src <= src_hold;
      if (src_hold != prev_src)       lag_cnt <= CW'(1);
      else if (src_hold != dst_level) lag_cnt <= (lag_cnt == CMAX) ? lag_cnt : lag_cnt + 1'b1;
      else                            lag_cnt <= '0;
    end
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      seen_hi <= 1'b0;
      seen_lo <= 1'b0;
    end else begin
      if (sync_first)      seen_hi <= 1'b1;
      else if (dst_level)  seen_hi <= 1'b0;
      if (!sync_first)     seen_lo <= 1'b1;
      else if (!dst_level) seen_lo <= 1'b0;
    end
  end

  // R1
  always @(posedge dst_clk) begin
    if (!dst_rst_n) begin
      a_r1_reset_low: assert (dst_level == 1'b0);
    end
  end

  // R2
  always @(posedge src_clk) begin
    if (!src_rst_n) begin
      a_r2_src_clear: assert (src_hold == 1'b0);
    end
  end

  // R6: a rise needs an earlier 1 in the first stage
  a_r6_rise_has_cause: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    $rose(dst_level) |-> seen_hi);

  // R6: a fall needs an earlier 0 in the first stage
  a_r6_fall_has_cause: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    $fell(dst_level) |-> seen_lo);

  // R7: bounded convergence
  a_r7_bounded_lag: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    lag_cnt <= LIMIT);
endmodule

bind cdc_level_sync cdc_level_sync_chk #(.STAGES(STAGES)) u_chk (
  .src_clk    (src_clk),
  .src_rst_n  (src_rst_n),
  .dst_clk    (dst_clk),
  .dst_rst_n  (dst_rst_n),
  .src_hold   (src_hold),
  .sync_first (sync_first),
  .dst_level  (dst_level)
);

// File: tb/cdc_level_sync_bench.sv
module cdc_level_sync_bench;
  timeunit 1ns;
  timeprecision 10ps;
  import cdc_level_pkg::*;

  localparam int  N_A = 2;
  localparam int  N_B = 3;
  localparam real TP  = 8.0;

  logic src_clk = 1'b0, dst_clk = 1'b0;
  logic src_rst_n = 1'b1, dst_rst_n = 1'b1;
  logic sa = 1'b0, sb = 1'b0;
  logic src_raw;
  logic out_a, out_b;

  // Glitchy combinational source: a skew between sa and sb makes hazards.
  assign src_raw = sa ^ sb;

  always #5.5 src_clk = ~src_clk;   // source edges at x.5 ns
  always #4   dst_clk = ~dst_clk;   // 125 MHz, edges on whole ns

  cdc_level_sync #(.STAGES(N_A), .FIRST_EDGE(CAPTURE_RISE)) u_cdc_level_sync (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_level_raw(src_raw),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_level(out_a));

  cdc_level_sync #(.STAGES(N_B), .FIRST_EDGE(CAPTURE_FALL)) u_cdc_level_sync_fall (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_level_raw(src_raw),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_level(out_b));

  // Reference model built from R3, R4, R5
  logic       m_src;
  logic [1:0] ma;
  logic       mb_first;
  logic [1:0] mb_tail;

  always @(posedge src_clk or negedge src_rst_n)
    if (!src_rst_n) m_src <= 1'b0; else m_src <= src_raw;
  always @(posedge dst_clk or negedge dst_rst_n)
    if (!dst_rst_n) ma <= 2'b00; else ma <= {ma[0], m_src};
  always @(negedge dst_clk or negedge dst_rst_n)
    if (!dst_rst_n) mb_first <= 1'b0; else mb_first <= m_src;
  always @(posedge dst_clk or negedge dst_rst_n)
    if (!dst_rst_n) mb_tail <= 2'b00; else mb_tail <= {mb_tail[0], mb_first};

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    run_cmp = 1'b0, done = 1'b0;
  int    tog_a = 0, tog_b = 0, mtog_a = 0, mtog_b = 0;
  logic  pa = 1'b0, pb = 1'b0, pma = 1'b0, pmb = 1'b0;

  task automatic check(string req, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $realtime);
    end
  endtask

  task automatic check_int(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic check_rng(string req, real got, real lo, real hi);
    n_chk++;
    if (!(got > lo && got <= hi)) begin
      n_fail++;
      $display("FAIL %s: latency %0.2f ns expected in (%0.2f, %0.2f]", req, got, lo, hi);
    end
  endtask

  // Per-cycle comparison, sampled 2 ns after the rising edge
  always @(posedge dst_clk) begin
    #2;
    if (run_cmp) begin
      check(cur_req, out_a, ma[1]);
      check(cur_req, out_b, mb_tail[1]);
      if (out_a !== pa)        tog_a++;
      if (out_b !== pb)        tog_b++;
      if (ma[1] !== pma)       mtog_a++;
      if (mb_tail[1] !== pmb)  mtog_b++;
      pa = out_a; pb = out_b; pma = ma[1]; pmb = mb_tail[1];
    end
  end

  // R4 and R5 latency sweep over source/destination phase offsets
  task automatic measure(int off);
    logic nv;
    real  t0, ta, tb;
    @(posedge src_clk);
    #(0.25 + off);
    nv = ~src_raw;
    sa = ~sa;
    @(posedge src_clk);
    t0 = $realtime;
    ta = -1.0;
    tb = -1.0;
    #0.25;
    for (int k = 0; k < 80; k++) begin
      if (ta < 0.0 && out_a === nv) ta = $realtime;
      if (tb < 0.0 && out_b === nv) tb = $realtime;
      #0.5;
    end
    check_rng("R4", ta - t0, TP * (N_A - 1), TP * N_A + 0.5);
    check_rng("R5", tb - t0, TP * (N_B - 1.5), TP * (N_B - 0.5) + 0.5);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * TP);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    logic held_a, held_b;
    void'($urandom(32'd20240519));
    #0.25;
    src_rst_n = 1'b0;
    dst_rst_n = 1'b0;
    sa = 1'b1;                       // raw high during reset
    #1;
    run_cmp = 1'b1;
    #29;
    check("R1", out_a, 1'b0);
    check("R1", out_b, 1'b0);
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    @(posedge dst_clk);
    #1;
    check("R1", out_a, 1'b0);        // first edge after release still 0

    // Random level changes
    cur_req = "R4 R5";
    repeat (300) begin
      #($urandom_range(1, 30));
      if ($urandom_range(0, 2) != 0) sa = ~sa;
    end
    #40;
    cur_req = "R7";
    check("R7", out_a, src_raw);
    check("R7", out_b, src_raw);

    // Hazards confined between two source edges
    cur_req = "R3";
    held_a = out_a;
    held_b = out_b;
    repeat (60) begin
      @(posedge src_clk);
      #1.25;
      if ($urandom_range(0, 1) == 1) begin
        sa = ~sa; #1; sb = ~sb;      // static hazard from skew
      end else begin
        sa = ~sa; #($urandom_range(1, 8)); sa = ~sa;   // short pulse
      end
    end
    #40;
    check("R3", out_a, held_a);
    check("R3", out_b, held_b);

    // Source-only reset with raw input high
    cur_req = "R2";
    sa = 1'b1; sb = 1'b0;
    #40;
    src_rst_n = 1'b0;
    #(N_B * TP + 10);
    check("R2", out_a, 1'b0);
    check("R2", out_b, 1'b0);
    src_rst_n = 1'b1;
    #40;
    check("R2", out_a, 1'b1);

    // Directed latency sweep
    cur_req = "R4 R5";
    for (int off = 0; off < 11; off++) begin
      measure(off);
      #40;
    end

    cur_req = "R7";
    #40;
    check("R7", out_a, src_raw);
    check("R7", out_b, src_raw);
    run_cmp = 1'b0;
    check_int("R6", tog_a, mtog_a);
    check_int("R6", tog_b, mtog_b);
    finish_run();
  end
endmodule